// File: doc/BRIEF.md
# Output-Compare and PWM Channel

This block is one output channel of a timer. It sits beside a shared free-running counter and compares the counter value against its own compare register. From that comparison and a 3-bit mode code it produces a reference waveform. The waveform is then qualified by an enable bit and a polarity bit to form the channel pin. The counter, its direction and its update event come from the surrounding timer. Software configures the channel through a small write port that has three targets: the mode byte, the compare value and the output-control bits.

The reference can stay frozen, be set, cleared or toggled on a match, be forced low or high, or produce edge-aligned PWM in either sense. PWM polarity follows the count direction. The compare value can be double-buffered so that it changes only on an update event. An external clear input can pull the reference low until the next update. A fast flag exposes the reference one register stage earlier. Every match between the counter and the active compare value produces a one-cycle flag pulse.

Top module: `oc_channel`

## Requirements
- R1: The mode code sits in bits 6:4 of the mode byte. Code 4 drives the reference low and code 5 drives it high, on the clock edge after the counter is sampled, whatever the counter value.
- R2: Code 0 (frozen) leaves the reference unchanged, even on a counter/compare match.
- R3: Code 1 sets the reference to 1 when the counter equals the compare value. Code 2 clears it to 0 on a match. Code 3 inverts it on a match. With no match, all three hold the reference.
- R4: Code 6 with up-counting (`cnt_down`=0) gives a reference of 1 while counter < compare and 0 otherwise. With down-counting it gives 0 while counter > compare and 1 otherwise.
- R5: Code 7 gives the inverse of code 6 in both directions.
- R6: `match_flag` is 1 for exactly the cycle after a clock edge at which the counter equalled the active compare value. This holds in every mode.
- R7: When bit 3 of the mode byte is set, a compare write goes to a buffer. The comparator sees the new value only after an edge where `upd_evt` is 1, and that edge itself still uses the old value. When bit 3 is clear, the comparator sees the write from the next edge on.
- R8: Output-control bit 0 is the enable and bit 1 is the polarity. Enabled, the pin is reference XOR polarity. Disabled, the pin sits at the polarity value (its inactive level).
- R9: When bit 7 of the mode byte is set and `clr_in` is 1 at an edge, the reference goes low. It stays low through the first edge with `upd_evt`=1 and is released after that edge. With bit 7 clear, `clr_in` has no effect.
- R10: When bit 2 of the mode byte is set, `oc_ref` shows the next reference value combinationally from the present counter input. When bit 2 is clear, `oc_ref` is the registered value.
- R11: Synchronous reset selects frozen mode with no flags, a compare value of 0, and the channel disabled with polarity 0. It also clears the reference, the clear latch and the match flag.
- R12: The write target `wr_sel` selects 0 for the mode byte (`wr_data[7:0]`), 1 for the compare value and 2 for output control. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Shared counter value |
| cnt_down | input | 1 | 1 when the counter counts down |
| upd_evt | input | 1 | Update event pulse from the timer |
| clr_in | input | 1 | External reference clear request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode byte, 1 compare, 2 output control, 3 none |
| wr_data | input | CW | Write data |
| pin | output | 1 | Channel output pin |
| oc_ref | output | 1 | Reference waveform before polarity and enable |
| match_flag | output | 1 | One-cycle pulse after a counter/compare match |

## Verification
The PWM boundary is probed at exactly the compare value in both count directions. A design that used < where <= belongs, or that ignored direction, would flip the reference on that single count. Preload is tested with the update on the same edge as a sample. A design that loaded the buffer too early would change the reference one count ahead of the update. The clear latch is followed through the update edge, where a latch released one edge early would show a high reference. The fast path is sampled between edges, where only a combinational reference can already have moved.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_FROZEN = 3'd0,
        OCM_SET    = 3'd1,
        OCM_CLR    = 3'd2,
        OCM_TOG    = 3'd3,
        OCM_LOW    = 3'd4,
        OCM_HIGH   = 3'd5,
        OCM_PWM_A  = 3'd6,
        OCM_PWM_B  = 3'd7
    } ocm_e;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_OUT  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    localparam int MODE_LSB     = 4;
    localparam int CLR_EN_BIT   = 7;
    localparam int PRELOAD_BIT  = 3;
    localparam int FAST_BIT     = 2;
    localparam int OUT_EN_BIT   = 0;
    localparam int OUT_POL_BIT  = 1;

    typedef struct packed {
        logic clr_en;
        ocm_e mode;
        logic pre_en;
        logic fast_en;
    } mode_cfg_t;

    typedef struct packed {
        logic en;
        logic pol;
    } out_cfg_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } cmp_res_t;

    function automatic mode_cfg_t decode_mode(input logic [7:0] b);
        mode_cfg_t c;
        c.clr_en  = b[CLR_EN_BIT];
        c.mode    = ocm_e'(b[MODE_LSB +: 3]);
        c.pre_en  = b[PRELOAD_BIT];
        c.fast_en = b[FAST_BIT];
        return c;
    endfunction

    // Next reference level from mode, present level and comparison.
    function automatic logic ref_eval(input ocm_e m, input logic cur,
                                      input cmp_res_t r, input logic down);
        logic pwm_a;
        pwm_a = down ? ~r.gt : r.lt;
        case (m)
            OCM_FROZEN: return cur;
            OCM_SET:    return r.eq ? 1'b1 : cur;
            OCM_CLR:    return r.eq ? 1'b0 : cur;
            OCM_TOG:    return r.eq ? ~cur : cur;
            OCM_LOW:    return 1'b0;
            OCM_HIGH:   return 1'b1;
            OCM_PWM_A:  return pwm_a;
            default:    return ~pwm_a;
        endcase
    endfunction

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [CW-1:0]   wr_data,
    input  logic            upd_evt,
    output mode_cfg_t       mcfg,
    output out_cfg_t        ocfg,
    output logic [CW-1:0]   cmp_act
);

    logic [CW-1:0] cmp_buf;
    wsel_e         sel;

    assign sel = wsel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mcfg    <= '0;
            ocfg    <= '0;
            cmp_buf <= '0;
            cmp_act <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_MODE: mcfg    <= decode_mode(wr_data[7:0]);
                    SEL_CMP:  cmp_buf <= wr_data;
                    SEL_OUT: begin
                        ocfg.en  <= wr_data[OUT_EN_BIT];
                        ocfg.pol <= wr_data[OUT_POL_BIT];
                    end
                    default: ;
                endcase
            end
            if (wr_en && sel == SEL_CMP && !mcfg.pre_en)
                cmp_act <= wr_data;
            else if (upd_evt)
                cmp_act <= cmp_buf;
        end
    end

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cnt_val,
    input  logic            cnt_down,
    input  logic            upd_evt,
    input  logic            clr_in,
    input  mode_cfg_t       mcfg,
    input  logic [CW-1:0]   cmp_act,
    output logic            ref_q,
    output logic            ref_out,
    output logic            clr_hold,
    output logic            match_q
);

    cmp_res_t res;
    logic     clr_now;
    logic     clr_force;
    logic     ref_d;

    assign res.eq = (cnt_val == cmp_act);
    assign res.lt = (cnt_val <  cmp_act);
    assign res.gt = (cnt_val >  cmp_act);

    assign clr_now   = mcfg.clr_en & clr_in;
    assign clr_force = clr_now | clr_hold;

    always_comb begin
        if (clr_force)
            ref_d = 1'b0;
        else
            ref_d = ref_eval(mcfg.mode, ref_q, res, cnt_down);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= 1'b0;
            clr_hold <= 1'b0;
            match_q  <= 1'b0;
        end else begin
            ref_q    <= ref_d;
            clr_hold <= clr_now | (clr_hold & ~upd_evt);
            match_q  <= res.eq;
        end
    end

    assign ref_out = mcfg.fast_en ? ref_d : ref_q;

endmodule

// File: rtl/oc_pin_drive.sv
module oc_pin_drive
    import oc_pkg::*;
(
    input  logic     ref_in,
    input  out_cfg_t ocfg,
    output logic     pin
);

    always_comb begin
        if (ocfg.en)
            pin = ref_in ^ ocfg.pol;
        else
            pin = ocfg.pol;
    end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cnt_val,
    input  logic            cnt_down,
    input  logic            upd_evt,
    input  logic            clr_in,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [CW-1:0]   wr_data,
    output logic            pin,
    output logic            oc_ref,
    output logic            match_flag
);

    mode_cfg_t      mcfg;
    out_cfg_t       ocfg;
    logic [CW-1:0]  cmp_act;
    logic           ref_q;
    logic           clr_hold;

    oc_cfg_regs #(.CW(CW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_evt (upd_evt),
        .mcfg    (mcfg),
        .ocfg    (ocfg),
        .cmp_act (cmp_act)
    );

    oc_ref_gen #(.CW(CW)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .cnt_val  (cnt_val),
        .cnt_down (cnt_down),
        .upd_evt  (upd_evt),
        .clr_in   (clr_in),
        .mcfg     (mcfg),
        .cmp_act  (cmp_act),
        .ref_q    (ref_q),
        .ref_out  (oc_ref),
        .clr_hold (clr_hold),
        .match_q  (match_flag)
    );

    oc_pin_drive u_pin (
        .ref_in (oc_ref),
        .ocfg   (ocfg),
        .pin    (pin)
    );

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cnt_val,
    input  logic            upd_evt,
    input  logic            pin,
    input  logic            match_flag,
    input  ocm_e            mode,
    input  logic            pre_en,
    input  logic            out_en,
    input  logic            out_pol,
    input  logic [CW-1:0]   cmp_act,
    input  logic            ref_q,
    input  logic            clr_hold,
    input  logic            clr_en,
    input  logic            clr_in
);

    logic force_off;
    assign force_off = clr_hold | (clr_en & clr_in);

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_HIGH && !force_off) |=> ref_q)
        else $error("force high not applied"); // R1

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_FROZEN && !force_off) |=> $stable(ref_q))
        else $error("frozen reference moved"); // R2

    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cnt_val == cmp_act) |=> match_flag)
        else $error("match flag missing"); // R6

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pre_en && !upd_evt) |=> $stable(cmp_act))
        else $error("buffered compare changed without update"); // R7

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (pin == out_pol))
        else $error("disabled pin not at inactive level"); // R8

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (rst)
        clr_hold |-> !ref_q)
        else $error("reference high while clear latched"); // R9

endmodule

bind oc_channel oc_channel_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_val    (cnt_val),
    .upd_evt    (upd_evt),
    .pin        (pin),
    .match_flag (match_flag),
    .mode       (mcfg.mode),
    .pre_en     (mcfg.pre_en),
    .out_en     (ocfg.en),
    .out_pol    (ocfg.pol),
    .cmp_act    (cmp_act),
    .ref_q      (ref_q),
    .clr_hold   (clr_hold),
    .clr_en     (mcfg.clr_en),
    .clr_in     (clr_in)
);

// File: tb/oc_channel_bench.sv
`timescale 1ns/1ps
module oc_channel_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt_val = '0;
    logic          cnt_down = 1'b0;
    logic          upd_evt = 1'b0;
    logic          clr_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic          pin;
    logic          oc_ref;
    logic          match_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    oc_channel #(.CW(CW)) u_oc_channel (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .clr_in(clr_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pin(pin), .oc_ref(oc_ref), .match_flag(match_flag)
    );

    typedef struct packed {
        logic [2:0]  m;
        logic        dn;
        logic [15:0] c;
        logic        r;
        logic        mt;
    } vec_t;

    // Compare value 5, channel enabled, polarity 0.
    localparam vec_t VEC [14] = '{
        '{3'd6, 1'b0, 16'd4, 1'b1, 1'b0},
        '{3'd6, 1'b0, 16'd5, 1'b0, 1'b1},
        '{3'd6, 1'b0, 16'd9, 1'b0, 1'b0},
        '{3'd6, 1'b1, 16'd6, 1'b0, 1'b0},
        '{3'd6, 1'b1, 16'd5, 1'b1, 1'b1},
        '{3'd6, 1'b1, 16'd2, 1'b1, 1'b0},
        '{3'd7, 1'b0, 16'd4, 1'b0, 1'b0},
        '{3'd7, 1'b0, 16'd5, 1'b1, 1'b1},
        '{3'd7, 1'b1, 16'd6, 1'b1, 1'b0},
        '{3'd7, 1'b1, 16'd5, 1'b0, 1'b1},
        '{3'd4, 1'b0, 16'd3, 1'b0, 1'b0},
        '{3'd5, 1'b0, 16'd5, 1'b1, 1'b1},
        '{3'd4, 1'b1, 16'd5, 1'b0, 1'b1},
        '{3'd5, 1'b1, 16'd0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [CW-1:0] data);
        cnt_val = 16'd100;
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic step(input logic [CW-1:0] c, input logic dn,
                        input logic up, input logic cl);
        cnt_val  = c;
        cnt_down = dn;
        upd_evt  = up;
        clr_in   = cl;
        tick();
        upd_evt  = 1'b0;
        clr_in   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R11: reset state
        @(negedge clk);
        repeat (3) tick();
        check("R11 pin", pin, 1'b0);
        check("R11 ref", oc_ref, 1'b0);
        check("R11 match", match_flag, 1'b0);
        rst = 1'b0;

        // R12: output control and compare targets
        wr(2'd2, 16'h0001);
        wr(2'd1, 16'd5);

        // Table: R1 force modes, R4 PWM1, R5 PWM2, R6 match pulse
        foreach (VEC[i]) begin
            wr(2'd0, {8'h00, 1'b0, VEC[i].m, 4'h0});
            step(VEC[i].c, VEC[i].dn, 1'b0, 1'b0);
            check(VEC[i].m >= 3'd6 ? "R4/R5 ref" : "R1 ref", oc_ref, VEC[i].r);
            check("R8 pin enabled", pin, VEC[i].r);
            check("R6 match", match_flag, VEC[i].mt);
        end

        // R2: frozen holds 1 and 0 across a match
        wr(2'd0, 16'h0050);
        step(16'd100, 1'b0, 1'b0, 1'b0);
        wr(2'd0, 16'h0000);
        step(16'd5, 1'b0, 1'b0, 1'b0);
        check("R2 frozen high", oc_ref, 1'b1);
        check("R6 match frozen", match_flag, 1'b1);
        wr(2'd0, 16'h0040);
        step(16'd100, 1'b0, 1'b0, 1'b0);
        wr(2'd0, 16'h0000);
        step(16'd5, 1'b0, 1'b0, 1'b0);
        check("R2 frozen low", oc_ref, 1'b0);

        // R3: set on match
        wr(2'd0, 16'h0010);
        step(16'd4, 1'b0, 1'b0, 1'b0);
        check("R3 set no match", oc_ref, 1'b0);
        step(16'd5, 1'b0, 1'b0, 1'b0);
        check("R3 set match", oc_ref, 1'b1);
        step(16'd6, 1'b0, 1'b0, 1'b0);
        check("R3 set hold", oc_ref, 1'b1);
        // R3: clear on match
        wr(2'd0, 16'h0020);
        step(16'd4, 1'b0, 1'b0, 1'b0);
        check("R3 clr no match", oc_ref, 1'b1);
        step(16'd5, 1'b0, 1'b0, 1'b0);
        check("R3 clr match", oc_ref, 1'b0);
        step(16'd7, 1'b0, 1'b0, 1'b0);
        check("R3 clr hold", oc_ref, 1'b0);
        // R3: toggle
        wr(2'd0, 16'h0030);
        step(16'd5, 1'b0, 1'b0, 1'b0);
        check("R3 toggle up", oc_ref, 1'b1);
        step(16'd6, 1'b0, 1'b0, 1'b0);
        check("R3 toggle hold", oc_ref, 1'b1);
        step(16'd5, 1'b1, 1'b0, 1'b0);
        check("R3 toggle down", oc_ref, 1'b0);

        // R8: polarity and enable, reference held high
        wr(2'd0, 16'h0050);
        step(16'd100, 1'b0, 1'b0, 1'b0);
        wr(2'd2, 16'h0000);
        check("R8 off pol0", pin, 1'b0);
        wr(2'd2, 16'h0002);
        check("R8 off pol1", pin, 1'b1);
        wr(2'd2, 16'h0003);
        check("R8 on pol1", pin, 1'b0);
        wr(2'd2, 16'h0001);
        check("R8 on pol0", pin, 1'b1);

        // R12: target 3 ignored
        wr(2'd3, 16'h0000);
        check("R12 sel3 pin", pin, 1'b1);
        step(16'd100, 1'b0, 1'b0, 1'b0);
        check("R12 sel3 mode", oc_ref, 1'b1);

        // R9: clear input without enable is ignored
        step(16'd100, 1'b0, 1'b0, 1'b1);
        check("R9 clear disabled", oc_ref, 1'b1);
        // R9: clear latch held until update
        wr(2'd0, 16'h00D0);
        step(16'd100, 1'b0, 1'b0, 1'b1);
        check("R9 clear low", oc_ref, 1'b0);
        step(16'd100, 1'b0, 1'b0, 1'b0);
        check("R9 clear held", oc_ref, 1'b0);
        step(16'd100, 1'b0, 1'b1, 1'b0);
        check("R9 clear at update", oc_ref, 1'b0);
        step(16'd100, 1'b0, 1'b0, 1'b0);
        check("R9 clear released", oc_ref, 1'b1);

        // R7: preload buffers compare until update
        wr(2'd0, 16'h0068);
        wr(2'd1, 16'd20);
        step(16'd10, 1'b0, 1'b0, 1'b0);
        check("R7 old compare", oc_ref, 1'b0);
        step(16'd10, 1'b0, 1'b1, 1'b0);
        check("R7 update edge old", oc_ref, 1'b0);
        step(16'd10, 1'b0, 1'b0, 1'b0);
        check("R7 new compare", oc_ref, 1'b1);
        step(16'd20, 1'b0, 1'b0, 1'b0);
        check("R7 match new", match_flag, 1'b1);
        // R7: direct write without preload
        wr(2'd0, 16'h0060);
        wr(2'd1, 16'd8);
        step(16'd7, 1'b0, 1'b0, 1'b0);
        check("R7 direct below", oc_ref, 1'b1);
        step(16'd8, 1'b0, 1'b0, 1'b0);
        check("R7 direct at", oc_ref, 1'b0);

        // R10: fast path
        step(16'd3, 1'b0, 1'b0, 1'b0);
        cnt_val = 16'd12;
        #1;
        check("R10 registered", oc_ref, 1'b1);
        tick();
        check("R10 registered after", oc_ref, 1'b0);
        wr(2'd0, 16'h0064);
        cnt_val = 16'd3;
        #1;
        check("R10 fast", oc_ref, 1'b1);
        check("R10 fast pin", pin, 1'b1);
        tick();

        finish_run();
    end

endmodule